// File: doc/BRIEF.md
# Word-to-Byte Payload Packer

This block sits between a pair of 32-bit payload FIFOs and a byte-serial bus engine. It runs one payload transfer at a time. A start strobe gives the direction and an unsigned 12-bit byte count. On a write, the block pops words from the transmit FIFO and hands them to the engine one byte at a time, lowest byte first. It drops whatever lanes of the final word the count does not cover. On a read, it gathers the bytes coming from the engine into words, filling from the most significant lane down. It pushes each word when the word fills up, or when the transfer ends partway through a word.

The block never pops an empty FIFO and never pushes into a full one. While it waits on a FIFO, it holds off the engine. The engine can end a transfer early through a stop strobe, for example when a read target ends its data. A one-cycle done pulse then reports how many bytes were actually moved. Bus signalling, the FIFOs and error reporting belong to other blocks.

Top module: `payload_packer`

## Requirements
- R1: After reset, busy_o, txf_pop_o, rxf_push_o, eng_tx_valid_o, eng_rx_ready_o and done_o are all 0.
- R2: On a write, byte k of the transfer is bits 8*(k mod 4)+7 down to 8*(k mod 4) of transmit word k/4. Bits 7:0 of a word go out first. The byte on eng_tx_byte_o stays stable while eng_tx_valid_o is high and eng_tx_ready_i is low.
- R3: On a write of length L, exactly ceil(L/4) words are popped. A word is popped only after every byte of the previous word has been accepted. The unused lanes of the final word are never presented, and the next FIFO word is not touched.
- R4: On a read, byte k of the transfer is written to bits 31-8*(k mod 4) down to 24-8*(k mod 4) of receive word k/4. The first byte lands in bits 31:24.
- R5: When a read ends partway through a word, that word is still pushed. Its valid bytes sit in the upper lanes, and its unused lower lanes read as zero.
- R6: A start with length 0 pops nothing, pushes nothing and leaves busy_o low. In the next cycle, done_o pulses with done_count_o equal to 0.
- R7: txf_pop_o is high only while txf_empty_i is low, and rxf_push_o is high only while rxf_full_i is low. While a word is waiting for the receive FIFO, eng_rx_ready_o stays low.
- R8: At the end of every transfer, done_o is high for one cycle. done_count_o then equals the number of bytes handshaked with the engine, which never exceeds the started length.
- R9: A start strobe while busy_o is high is ignored. The running transfer's data, pops and count are unchanged, and no second transfer follows.
- R10: Lengths up to 4095 are handled in full.
- R11: eng_stop_i during a transfer ends it. A byte handshaked in the same cycle still counts. On a write, no further word is popped and the rest of the current word is dropped. On a read, a partly filled word is pushed as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| start_rnw_i | input | 1 | 1 = read (bus to receive FIFO), 0 = write |
| start_len_i | input | 12 | Transfer length in bytes |
| busy_o | output | 1 | Transfer in progress |
| txf_data_i | input | 32 | Head word of transmit FIFO (show-ahead) |
| txf_empty_i | input | 1 | Transmit FIFO empty |
| txf_pop_o | output | 1 | Pop transmit FIFO head |
| rxf_data_o | output | 32 | Word to push into receive FIFO |
| rxf_full_i | input | 1 | Receive FIFO full |
| rxf_push_o | output | 1 | Push rxf_data_o |
| eng_tx_byte_o | output | 8 | Byte offered to the engine |
| eng_tx_valid_o | output | 1 | eng_tx_byte_o is valid |
| eng_tx_ready_i | input | 1 | Engine takes the byte this cycle |
| eng_rx_byte_i | input | 8 | Byte from the engine |
| eng_rx_valid_i | input | 1 | eng_rx_byte_i is valid |
| eng_rx_ready_o | output | 1 | Packer takes the byte this cycle |
| eng_stop_i | input | 1 | Engine ends the transfer early |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| done_count_o | output | 12 | Bytes moved, valid with done_o |

## Verification
A wrong byte-lane pointer shows up as the wrong byte at the very next handshake on the engine side. On a read, it shows up in the next pushed word, because the bench compares every byte and every word as it happens. A stale word-held flag shows up within one cycle. It causes either an extra pop, which is seen after the transfer as a missing sentinel word in the transmit FIFO, or a missing pop, which stalls the byte stream until the watchdog. A wrong remaining-count shows up at done_o, either as a wrong count or as a pulse that comes early or late, and the same error makes the byte stream too long or too short.

// File: rtl/payload_packer_pkg.sv
package payload_packer_pkg;
  typedef enum logic [1:0] {
    PK_IDLE  = 2'd0,
    PK_TX    = 2'd1,
    PK_RX    = 2'd2,
    PK_FLUSH = 2'd3
  } pk_state_e;
endpackage

// File: rtl/payload_packer_ctrl.sv
module payload_packer_ctrl
  import payload_packer_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rnw_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             stop_i,
  input  logic             tx_hs_i,
  input  logic             rx_hs_i,
  input  logic             rx_pend_i,
  output pk_state_e        state_o,
  output logic             last_o,
  output logic             rx_final_o,
  output logic             done_o,
  output logic [LEN_W-1:0] done_count_o
);
  pk_state_e        state_q;
  logic [LEN_W-1:0] rem_q, cnt_q, dcnt_q;
  logic             done_q;

  assign last_o       = rem_q == LEN_W'(1);
  assign rx_final_o   = (state_q == PK_RX) && ((rx_hs_i && last_o) || stop_i);
  assign state_o      = state_q;
  assign done_o       = done_q;
  assign done_count_o = dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PK_IDLE;
      rem_q   <= '0;
      cnt_q   <= '0;
      dcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        PK_IDLE: begin
          if (start_i) begin
            cnt_q <= '0;
            rem_q <= len_i;
            if (len_i == '0) begin
              done_q <= 1'b1;
              dcnt_q <= '0;
            end else begin
              state_q <= rnw_i ? PK_RX : PK_TX;
            end
          end
        end
        PK_TX: begin
          if (tx_hs_i) begin
            rem_q <= rem_q - LEN_W'(1);
            cnt_q <= cnt_q + LEN_W'(1);
          end
          if ((tx_hs_i && last_o) || stop_i) begin
            state_q <= PK_IDLE;
            done_q  <= 1'b1;
            dcnt_q  <= cnt_q + LEN_W'(tx_hs_i);
          end
        end
        PK_RX: begin
          if (rx_hs_i) begin
            rem_q <= rem_q - LEN_W'(1);
            cnt_q <= cnt_q + LEN_W'(1);
          end
          if (rx_final_o) state_q <= PK_FLUSH;
        end
        default: begin
          // wait for the last gathered word to leave
          if (!rx_pend_i) begin
            state_q <= PK_IDLE;
            done_q  <= 1'b1;
            dcnt_q  <= cnt_q;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/payload_packer_tx.sv
module payload_packer_tx #(
  parameter int BYTE_W = 8,
  parameter int BPW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  stop_i,
  input  logic                  last_i,
  input  logic [BYTE_W*BPW-1:0] word_i,
  input  logic                  empty_i,
  output logic                  pop_o,
  output logic [BYTE_W-1:0]     byte_o,
  output logic                  valid_o,
  input  logic                  ready_i,
  output logic                  hs_o
);
  localparam int WORD_W = BYTE_W * BPW;
  localparam int SLOT_W = $clog2(BPW);

  logic [WORD_W-1:0] wrd_q;
  logic [SLOT_W-1:0] slot_q;
  logic              have_q;
  logic [BYTE_W-1:0] lane [BPW];

  for (genvar g = 0; g < BPW; g++) begin : g_lane
    assign lane[g] = wrd_q[g*BYTE_W +: BYTE_W];
  end

  assign pop_o   = en_i && !have_q && !empty_i && !stop_i;
  assign valid_o = en_i && have_q;
  assign hs_o    = valid_o && ready_i;
  assign byte_o  = lane[slot_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrd_q  <= '0;
      slot_q <= '0;
      have_q <= 1'b0;
    end else if (!en_i) begin
      have_q <= 1'b0;
    end else if (pop_o) begin
      wrd_q  <= word_i;
      slot_q <= '0;
      have_q <= 1'b1;
    end else if (hs_o) begin
      slot_q <= (slot_q == SLOT_W'(BPW-1)) ? '0 : slot_q + SLOT_W'(1);
      // leftover lanes of the final word are dropped here
      if (slot_q == SLOT_W'(BPW-1) || last_i) have_q <= 1'b0;
    end
  end
endmodule

// File: rtl/payload_packer_rx.sv
module payload_packer_rx #(
  parameter int BYTE_W = 8,
  parameter int BPW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  final_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic                  valid_i,
  output logic                  ready_o,
  output logic                  hs_o,
  input  logic                  full_i,
  output logic                  push_o,
  output logic [BYTE_W*BPW-1:0] word_o,
  output logic                  pend_o
);
  localparam int WORD_W = BYTE_W * BPW;
  localparam int SLOT_W = $clog2(BPW);

  logic [SLOT_W-1:0] slot_q;
  logic              pend_q;
  wire  [WORD_W-1:0] word_w;

  assign ready_o = en_i && !pend_q;
  assign hs_o    = ready_o && valid_i;
  assign push_o  = pend_q && !full_i;
  assign pend_o  = pend_q;
  assign word_o  = word_w;

  // lane 0 is the most significant byte
  for (genvar g = 0; g < BPW; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (push_o)                            q <= '0;
      else if (hs_o && slot_q == SLOT_W'(g))      q <= byte_i;
    end
    assign word_w[WORD_W-1-g*BYTE_W -: BYTE_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      pend_q <= 1'b0;
    end else if (push_o) begin
      slot_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (hs_o) slot_q <= (slot_q == SLOT_W'(BPW-1)) ? '0 : slot_q + SLOT_W'(1);
      if (hs_o && (slot_q == SLOT_W'(BPW-1) || final_i)) pend_q <= 1'b1;
      else if (final_i && slot_q != '0)                  pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/payload_packer.sv
module payload_packer
  import payload_packer_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int BYTE_W = 8,
  parameter int BPW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  start_rnw_i,
  input  logic [LEN_W-1:0]      start_len_i,
  output logic                  busy_o,
  input  logic [BYTE_W*BPW-1:0] txf_data_i,
  input  logic                  txf_empty_i,
  output logic                  txf_pop_o,
  output logic [BYTE_W*BPW-1:0] rxf_data_o,
  input  logic                  rxf_full_i,
  output logic                  rxf_push_o,
  output logic [BYTE_W-1:0]     eng_tx_byte_o,
  output logic                  eng_tx_valid_o,
  input  logic                  eng_tx_ready_i,
  input  logic [BYTE_W-1:0]     eng_rx_byte_i,
  input  logic                  eng_rx_valid_i,
  output logic                  eng_rx_ready_o,
  input  logic                  eng_stop_i,
  output logic                  done_o,
  output logic [LEN_W-1:0]      done_count_o
);
  pk_state_e state;
  logic      last, rx_final, tx_hs, rx_hs, rx_pend;

  assign busy_o = state != PK_IDLE;

  payload_packer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i      (start_i),
    .rnw_i        (start_rnw_i),
    .len_i        (start_len_i),
    .stop_i       (eng_stop_i),
    .tx_hs_i      (tx_hs),
    .rx_hs_i      (rx_hs),
    .rx_pend_i    (rx_pend),
    .state_o      (state),
    .last_o       (last),
    .rx_final_o   (rx_final),
    .done_o       (done_o),
    .done_count_o (done_count_o)
  );

  payload_packer_tx #(.BYTE_W(BYTE_W), .BPW(BPW)) u_tx (
    .clk_i, .rst_ni,
    .en_i    (state == PK_TX),
    .stop_i  (eng_stop_i),
    .last_i  (last),
    .word_i  (txf_data_i),
    .empty_i (txf_empty_i),
    .pop_o   (txf_pop_o),
    .byte_o  (eng_tx_byte_o),
    .valid_o (eng_tx_valid_o),
    .ready_i (eng_tx_ready_i),
    .hs_o    (tx_hs)
  );

  payload_packer_rx #(.BYTE_W(BYTE_W), .BPW(BPW)) u_rx (
    .clk_i, .rst_ni,
    .en_i    (state == PK_RX),
    .final_i (rx_final),
    .byte_i  (eng_rx_byte_i),
    .valid_i (eng_rx_valid_i),
    .ready_o (eng_rx_ready_o),
    .hs_o    (rx_hs),
    .full_i  (rxf_full_i),
    .push_o  (rxf_push_o),
    .word_o  (rxf_data_o),
    .pend_o  (rx_pend)
  );
endmodule

// File: rtl/payload_packer_chk.sv
module payload_packer_chk #(
  parameter int LEN_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [LEN_W-1:0]  start_len_i,
  input logic              busy_o,
  input logic              txf_empty_i,
  input logic              txf_pop_o,
  input logic              rxf_full_i,
  input logic              rxf_push_o,
  input logic [BYTE_W-1:0] eng_tx_byte_o,
  input logic              eng_tx_valid_o,
  input logic              eng_tx_ready_i,
  input logic              eng_stop_i,
  input logic              eng_rx_ready_o,
  input logic              done_o,
  input logic [LEN_W-1:0]  done_count_o
);
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 len_q <= '0;
    else if (start_i && !busy_o) len_q <= start_len_i;
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_pop_o |-> !txf_empty_i);  // R7
  AST_PUSH_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_push_o |-> !rxf_full_i);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !txf_pop_o && !rxf_push_o && !eng_tx_valid_o && !eng_rx_ready_o);  // R6
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && start_len_i == '0) |=> done_o && done_count_o == '0);  // R6
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> done_count_o <= len_q);  // R8
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_tx_valid_o && !eng_tx_ready_i && !eng_stop_i) |=> eng_tx_valid_o && $stable(eng_tx_byte_o));  // R2
endmodule

bind payload_packer payload_packer_chk #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_payload_packer.sv
module sim_payload_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, start_rnw_i = 1'b0;
  logic [11:0] start_len_i = '0;
  logic        busy_o;
  logic [31:0] txf_data_i = '0;
  logic        txf_empty_i = 1'b1, txf_pop_o;
  logic [31:0] rxf_data_o;
  logic        rxf_full_i = 1'b0, rxf_push_o;
  logic [7:0]  eng_tx_byte_o;
  logic        eng_tx_valid_o, eng_tx_ready_i = 1'b0;
  logic [7:0]  eng_rx_byte_i = '0;
  logic        eng_rx_valid_i = 1'b0, eng_rx_ready_o, eng_stop_i = 1'b0;
  logic        done_o;
  logic [11:0] done_count_o;

  always #10 clk_i = ~clk_i;

  payload_packer u0 (.*);

  int total = 0, bad = 0, cyc = 0, hs_cnt = 0, stop_at = -1, exp_done = 0, seed = 0;
  bit stall = 0, stop_sent = 0, got_done = 0, pend_pop = 0, pend_rx = 0, finished = 0;
  logic [31:0] txq[$];
  logic [31:0] exp_rx[$];
  logic [7:0]  exp_tx[$];
  logic [7:0]  rx_src[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(int i);
    return 8'((i * 37 + seed) & 255);
  endfunction

  // reference engine, FIFOs and scoreboard, stepped every clock
  always @(negedge clk_i) begin
    if (pend_pop) void'(txq.pop_front());
    if (pend_rx)  void'(rx_src.pop_front());
    pend_pop = 0;
    pend_rx  = 0;
    cyc++;
    txf_empty_i    = (txq.size() == 0) || (stall && (cyc % 5 < 2));
    txf_data_i     = (txq.size() != 0) ? txq[0] : 32'h0;
    eng_tx_ready_i = !stall || (cyc % 3 != 1);
    eng_rx_valid_i = (rx_src.size() != 0) && (!stall || (cyc % 4 != 2));
    eng_rx_byte_i  = (rx_src.size() != 0) ? rx_src[0] : 8'h0;
    rxf_full_i     = stall && (cyc % 7 < 3);
    if (stop_at >= 0 && hs_cnt == stop_at && !stop_sent && busy_o) begin
      eng_stop_i     = 1'b1;
      stop_sent      = 1;
      eng_tx_ready_i = 1'b0;
      eng_rx_valid_i = 1'b0;
    end else begin
      eng_stop_i = 1'b0;
    end
    #1;
    if (txf_pop_o) pend_pop = 1;
    if (txf_empty_i) chk(!txf_pop_o, "R7 pop while empty", int'(txf_pop_o), 0);
    if (rxf_full_i && busy_o) chk(!rxf_push_o, "R7 push while full", int'(rxf_push_o), 0);
    if (eng_tx_valid_o && eng_tx_ready_i) begin
      hs_cnt++;
      if (exp_tx.size() == 0) chk(0, "R3 extra tx byte", int'(eng_tx_byte_o), -1);
      else begin
        chk(eng_tx_byte_o == exp_tx[0], "R2 tx byte order", int'(eng_tx_byte_o), int'(exp_tx[0]));
        void'(exp_tx.pop_front());
      end
    end
    if (eng_rx_ready_o && eng_rx_valid_i) begin
      hs_cnt++;
      pend_rx = 1;
    end
    if (rxf_push_o) begin
      if (exp_rx.size() == 0) chk(0, "R4 extra push", int'(rxf_data_o), -1);
      else begin
        chk(rxf_data_o == exp_rx[0], "R4/R5 rx word", int'(rxf_data_o), int'(exp_rx[0]));
        void'(exp_rx.pop_front());
      end
    end
    if (done_o) begin
      chk(!got_done, "R8 single done", 1, 0);
      got_done = 1;
      chk(int'(done_count_o) == exp_done, "R8 done count", int'(done_count_o), exp_done);
    end
  end

  task automatic run(bit rnw, int len, int stop_k, bit stl, int inject_at);
    int n, nw, uw;
    n  = (stop_k >= 0) ? stop_k : len;
    nw = (len + 3) / 4;
    uw = (n + 3) / 4;
    seed += 11;
    txq.delete(); exp_tx.delete(); exp_rx.delete(); rx_src.delete();
    hs_cnt = 0; stop_sent = 0; got_done = 0;
    stop_at = stop_k; stall = stl; exp_done = n;
    if (!rnw) begin
      for (int w = 0; w < nw; w++)
        txq.push_back({bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)});
      txq.push_back(32'hA5A5_5A5A);
      for (int i = 0; i < n; i++) exp_tx.push_back(bval(i));
    end else begin
      for (int i = 0; i < len; i++) rx_src.push_back(bval(i));
      for (int k = 0; k < uw; k++) begin
        logic [31:0] w;
        w = '0;
        for (int j = 0; j < 4; j++)
          if (4*k + j < n) w[31-8*j -: 8] = bval(4*k + j);
        exp_rx.push_back(w);
      end
    end
    @(negedge clk_i);
    start_i = 1'b1; start_rnw_i = rnw; start_len_i = 12'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    if (inject_at > 0) begin
      repeat (inject_at) @(negedge clk_i);
      chk(busy_o, "R9 busy at inject", int'(busy_o), 1);
      start_i = 1'b1; start_rnw_i = !rnw; start_len_i = 12'd3;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!got_done) @(posedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R9 idle after done", int'(busy_o), 0);
    if (!rnw) begin
      chk(exp_tx.size() == 0, "R3 tx bytes missing", exp_tx.size(), 0);
      chk(txq.size() == nw - uw + 1, "R3/R11 words popped", nw - txq.size() + 1, uw);
      if (txq.size() != 0)
        chk(txq[txq.size()-1] == 32'hA5A5_5A5A, "R3 next word kept", int'(txq[txq.size()-1]), 32'hA5A5_5A5A);
    end else begin
      chk(exp_rx.size() == 0, "R5 rx words missing", exp_rx.size(), 0);
    end
    stop_at = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk(!busy_o && !txf_pop_o && !rxf_push_o && !eng_tx_valid_o && !eng_rx_ready_o && !done_o,
        "R1 reset state", {busy_o, txf_pop_o, rxf_push_o, eng_tx_valid_o, eng_rx_ready_o, done_o}, 0);
    run(0, 5, -1, 0, 0);    // R2 R3 partial final word
    run(0, 1, -1, 0, 0);    // R3
    run(0, 8, -1, 0, 0);    // R2
    run(0, 7, -1, 1, 0);    // R7 stalls
    run(1, 10, -1, 0, 0);   // R4 R5
    run(1, 4, -1, 0, 0);    // R4
    run(1, 1, -1, 1, 0);    // R5 R7
    run(1, 13, -1, 1, 0);   // R7
    run(0, 12, 6, 0, 0);    // R11 write stop
    run(1, 12, 6, 0, 0);    // R11 read stop partial
    run(1, 12, 8, 1, 0);    // R11 read stop on word boundary
    run(0, 9, -1, 0, 4);    // R9 start while busy
    // R6 zero length
    exp_done = 0; got_done = 0;
    @(negedge clk_i);
    start_i = 1'b1; start_rnw_i = 1'b0; start_len_i = 12'd0;
    @(negedge clk_i);
    start_i = 1'b0; #2;
    chk(done_o && done_count_o == 0 && !busy_o && !txf_pop_o, "R6 zero length",
        {done_o, busy_o, txf_pop_o}, 3'b100);
    repeat (2) @(negedge clk_i);
    run(0, 4095, -1, 0, 0); // R10 full length
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule